// File: doc/BRIEF.md
# Nested Exception Resolution Unit

This unit settles the outcome when delivery of an injected event is interrupted by a second exception. Each request carries four inputs: the severity class of the event being delivered, the vector of the second exception, a 32-bit trap mask supplied by the hypervisor, and a flag that enables virtualization-exception support. The unit sorts the second vector into a severity class. It then returns exactly one outcome:

- leave the guest;
- deliver the second exception as it is;
- raise a double fault.

A request is taken on a valid/ready handshake. The outcome is registered and appears one cycle later on a second valid/ready pair. That output register can hold one outcome while the consumer applies back-pressure. Descriptor lookup, triple-fault handling and the delivery mechanics themselves live elsewhere.

Top module: `nested_fault_arbiter`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: When the second vector is below 32 and its bit in `req_trap_mask` is 1, the outcome is exit (`rsp_action` = 3'b001) with `rsp_vector` equal to the second vector. This holds whatever the severities are.
- R3: Second vectors of 32 and above never index the mask, never cause an exit, and are always delivered (`rsp_action` = 3'b010) with their own vector.
- R4: When the mask bit is 0, a benign second exception is delivered (3'b010, own vector) for every class of the first event.
- R5: Vectors 0, 10, 11, 12 and 13 are contributory. If the first event is contributory (`req_orig_sev` = 2'd1), the outcome is a double fault (3'b100) with `rsp_vector` = 8. If the first event is benign (2'd0), the second exception is delivered.
- R6: Vector 14 has page-fault severity. If the first event is a page fault (2'd2), the outcome is a double fault with vector 8. If the first event is contributory, vector 14 is delivered.
- R7: If the first event is a page fault and the second exception is contributory, the outcome is a double fault with vector 8.
- R8: With `req_ve_en` = 0, vector 20 is benign. With `req_ve_en` = 1, vector 20 has page-fault severity: after a page fault it gives a double fault, and after a contributory event it is delivered.
- R9: The reserved vectors 15 and 21 to 31 are benign, so they are delivered even after a page-fault first event. First-class code 2'd3 is treated as benign.
- R10: An outcome appears on `rsp_*` in the cycle after its request is accepted. It stays unchanged while `rsp_ready` is 0. `req_ready` is 0 while an outcome is held and not taken.
- R11: Whenever `rsp_valid` is 1, `rsp_action` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_orig_sev | input | 2 | Class of the event being delivered: 0 benign, 1 contributory, 2 page fault, 3 treated as benign |
| req_vector | input | 8 | Vector of the second exception |
| req_trap_mask | input | 32 | Per-vector exit mask |
| req_ve_en | input | 1 | Virtualization-exception support enable |
| rsp_valid | output | 1 | Outcome present |
| rsp_ready | input | 1 | Consumer takes the outcome |
| rsp_action | output | 3 | One-hot outcome: bit0 exit, bit1 deliver, bit2 double fault |
| rsp_vector | output | 8 | Resulting vector |

## Verification
Two rules can apply to the same request: the trap-mask exit and double-fault escalation. The bench provokes this by setting the mask bit for a contributory or page-fault vector that follows an escalating first event. The outcome is judged correct only if it is an exit that carries the second vector rather than vector 8. The other collision is between a request being accepted and a held outcome being taken in the same cycle. A pseudo-random `rsp_ready` pattern during the full sweep creates it. The scoreboard then confirms that nothing is lost, duplicated or altered while the outcome is held.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

   // Severity classes; the encoding is visible on req_orig_sev.
   typedef enum logic [1:0] {
      SEV_BENIGN  = 2'd0,
      SEV_CONTRIB = 2'd1,
      SEV_PAGE    = 2'd2,
      SEV_RSVD    = 2'd3
   } sev_e;

   // One-hot outcome codes; the encoding is visible on rsp_action.
   typedef enum logic [2:0] {
      ACT_EXIT    = 3'b001,
      ACT_DELIVER = 3'b010,
      ACT_DOUBLE  = 3'b100
   } act_e;

   localparam int unsigned ACT_W = 3;
   localparam int unsigned SEV_W = 2;

endpackage

// File: rtl/nfr_severity.sv
// Sorts a vector into a severity class and looks up its exit-mask bit.
module nfr_severity
   import nfr_pkg::*;
#(
   parameter int unsigned      VEC_W        = 8,
   parameter int unsigned      MAP_W        = 32,
   parameter int unsigned      PF_VEC       = 14,
   parameter int unsigned      VE_VEC       = 20,
   parameter logic [MAP_W-1:0] CONTRIB_MASK = 32'h0000_3C01
) (
   input  logic [VEC_W-1:0] vec,
   input  logic [MAP_W-1:0] trap_mask,
   input  logic             ve_en,
   output sev_e             sev,
   output logic             trap_hit
);

   localparam int unsigned IDX_W = $clog2(MAP_W);

   // Elaboration checks on the parameter set.
   if (MAP_W != (1 << IDX_W))
      $error("nfr_severity: MAP_W must be a power of two");
   if (IDX_W > VEC_W)
      $error("nfr_severity: MAP_W exceeds the vector range");
   if (PF_VEC >= MAP_W || VE_VEC >= MAP_W)
      $error("nfr_severity: special vectors must lie inside the mask");
   if (CONTRIB_MASK[PF_VEC] || CONTRIB_MASK[VE_VEC])
      $error("nfr_severity: special vectors may not be contributory");

   sev_e sev_tab [MAP_W];

   // One table entry per masked vector. The generate picks the entry
   // variant: feature-dependent, page fault, contributory or benign.
   for (genvar i = 0; i < MAP_W; i++) begin : g_tab
      if (i == VE_VEC) begin : g_ve
         assign sev_tab[i] = ve_en ? SEV_PAGE : SEV_BENIGN;
      end else if (i == PF_VEC) begin : g_pf
         assign sev_tab[i] = SEV_PAGE;
      end else if (CONTRIB_MASK[i]) begin : g_ct
         assign sev_tab[i] = SEV_CONTRIB;
      end else begin : g_bn
         assign sev_tab[i] = SEV_BENIGN;
      end
   end

   logic             in_range;
   logic [IDX_W-1:0] idx;

   if (IDX_W == VEC_W) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_part
      assign in_range = (vec[VEC_W-1:IDX_W] == '0);
   end

   assign idx      = vec[IDX_W-1:0];
   assign sev      = in_range ? sev_tab[idx] : SEV_BENIGN;
   assign trap_hit = in_range & trap_mask[idx];

endmodule

// File: rtl/nfr_escalate.sv
// Resolves the outcome from the two severity classes and the mask hit.
module nfr_escalate
   import nfr_pkg::*;
#(
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned DF_VEC = 8
) (
   input  sev_e             first_sev,
   input  sev_e             nested_sev,
   input  logic             trap_hit,
   input  logic [VEC_W-1:0] nested_vec,
   output act_e             act,
   output logic [VEC_W-1:0] out_vec
);

   if (DF_VEC >= (1 << VEC_W))
      $error("nfr_escalate: DF_VEC does not fit VEC_W");

   logic nested_grave;
   logic escalate;

   assign nested_grave = (nested_sev == SEV_CONTRIB) || (nested_sev == SEV_PAGE);

   always_comb begin
      unique case (first_sev)
         SEV_CONTRIB: escalate = (nested_sev == SEV_CONTRIB);
         SEV_PAGE:    escalate = nested_grave;
         default:     escalate = 1'b0;
      endcase
   end

   // The mask hit is decided ahead of any severity rule.
   always_comb begin
      if (trap_hit) begin
         act     = ACT_EXIT;
         out_vec = nested_vec;
      end else if (escalate) begin
         act     = ACT_DOUBLE;
         out_vec = VEC_W'(DF_VEC);
      end else begin
         act     = ACT_DELIVER;
         out_vec = nested_vec;
      end
   end

endmodule

// File: rtl/nfr_out_stage.sv
// Single-entry registered output with a valid/ready handshake.
module nfr_out_stage
   import nfr_pkg::*;
#(
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [ACT_W-1:0] in_act,
   input  logic [VEC_W-1:0] in_vec,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ACT_W-1:0] out_act,
   output logic [VEC_W-1:0] out_vec
);

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_act <= '0;
         out_vec <= '0;
      end else if (take) begin
         out_act <= in_act;
         out_vec <= in_vec;
      end
   end

   // R10: a held outcome does not change
   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_act) && $stable(out_vec));

   // R10: no new request is taken while an outcome waits
   a_r10_block_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R11: exactly one outcome bit
   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_act) == 1);

endmodule

// File: rtl/nested_fault_arbiter.sv
module nested_fault_arbiter
   import nfr_pkg::*;
#(
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned MAP_W  = 32,
   parameter int unsigned DF_VEC = 8,
   parameter int unsigned PF_VEC = 14,
   parameter int unsigned VE_VEC = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_orig_sev,
   input  logic [VEC_W-1:0] req_vector,
   input  logic [MAP_W-1:0] req_trap_mask,
   input  logic             req_ve_en,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [2:0]       rsp_action,
   output logic [VEC_W-1:0] rsp_vector
);

   localparam int unsigned IDX_W = $clog2(MAP_W);

   if (VEC_W < 5)
      $error("nested_fault_arbiter: VEC_W too small for architectural vectors");

   sev_e             first_sev;
   sev_e             nested_sev;
   logic             trap_hit;
   act_e             res_act;
   logic [VEC_W-1:0] res_vec;

   assign first_sev = sev_e'(req_orig_sev);

   nfr_severity #(
      .VEC_W  (VEC_W),
      .MAP_W  (MAP_W),
      .PF_VEC (PF_VEC),
      .VE_VEC (VE_VEC)
   ) u_sev (
      .vec       (req_vector),
      .trap_mask (req_trap_mask),
      .ve_en     (req_ve_en),
      .sev       (nested_sev),
      .trap_hit  (trap_hit)
   );

   nfr_escalate #(
      .VEC_W  (VEC_W),
      .DF_VEC (DF_VEC)
   ) u_esc (
      .first_sev  (first_sev),
      .nested_sev (nested_sev),
      .trap_hit   (trap_hit),
      .nested_vec (req_vector),
      .act        (res_act),
      .out_vec    (res_vec)
   );

   nfr_out_stage #(
      .VEC_W (VEC_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_act    (res_act),
      .in_vec    (res_vec),
      .out_valid (rsp_valid),
      .out_ready (rsp_ready),
      .out_act   (rsp_action),
      .out_vec   (rsp_vector)
   );

   logic acc;
   logic low_vec;

   assign acc     = req_valid && req_ready;
   assign low_vec = (req_vector >> IDX_W) == '0;

   // R2: a set mask bit below the mask width forces an exit
   a_r2_mask_exit: assert property (@(posedge clk) disable iff (!rst_n)
      acc && low_vec && req_trap_mask[req_vector[IDX_W-1:0]]
      |=> rsp_valid && rsp_action == 3'b001 && rsp_vector == $past(req_vector));

   // R3: vectors outside the mask are delivered unchanged
   a_r3_high_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !low_vec |=> rsp_action == 3'b010 && rsp_vector == $past(req_vector));

   // R5: a double fault always carries the double-fault vector
   a_r5_df_vector: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_action == 3'b100 |-> rsp_vector == VEC_W'(DF_VEC));

   // R10: an accepted request shows up on the next cycle
   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

endmodule

// File: tb/tb_nested_fault_arbiter.sv
module tb_nested_fault_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_orig_sev = '0;
   logic [7:0]  req_vector = '0;
   logic [31:0] req_trap_mask = '0;
   logic        req_ve_en = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [2:0]  rsp_action;
   logic [7:0]  rsp_vector;

   always #5 clk = ~clk;

   nested_fault_arbiter dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_orig_sev  (req_orig_sev),
      .req_vector    (req_vector),
      .req_trap_mask (req_trap_mask),
      .req_ve_en     (req_ve_en),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_action    (rsp_action),
      .rsp_vector    (rsp_vector)
   );

   typedef struct {
      logic [2:0] act;
      logic [7:0] vec;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   bit   bp_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
      end
   endtask

   // Reference outcome written from the requirement list.
   function automatic exp_t model(input logic [1:0] first, input logic [7:0] v,
                                  input logic [31:0] mask, input logic ve, input string tag);
      exp_t e;
      int   nsev;
      e.tag = tag;
      if (v < 32 && mask[v[4:0]]) begin
         e.act = 3'b001;
         e.vec = v;
         return e;
      end
      if (v == 0 || (v >= 10 && v <= 13)) nsev = 1;
      else if (v == 14 || (v == 20 && ve)) nsev = 2;
      else nsev = 0;
      if ((first == 2'd1 && nsev == 1) || (first == 2'd2 && nsev != 0)) begin
         e.act = 3'b100;
         e.vec = 8'd8;
      end else begin
         e.act = 3'b010;
         e.vec = v;
      end
      return e;
   endfunction

   // Driver: presents one request and queues its expected outcome at acceptance.
   task automatic send(input logic [1:0] first, input logic [7:0] v,
                       input logic [31:0] mask, input logic ve, input string tag);
      @(posedge clk); #1;
      req_valid     = 1'b1;
      req_orig_sev  = first;
      req_vector    = v;
      req_trap_mask = mask;
      req_ve_en     = ve;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      q.push_back(model(first, v, mask, ve, tag));
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   // Back-pressure generator: changes rsp_ready just after each rising edge.
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rsp_ready = bp_on ? lfsr[0] : 1'b1;
      end
   end

   // Monitor: pops the scoreboard when an outcome is taken, checks holds.
   logic       held = 1'b0;
   logic [2:0] held_act;
   logic [7:0] held_vec;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (held) begin
               // R10: a held outcome stays
               check(rsp_valid && rsp_action == held_act && rsp_vector == held_vec,
                     "R10 hold", {21'd0, rsp_valid, rsp_action, rsp_vector},
                     {21'd0, 1'b1, held_act, held_vec});
            end
            if (rsp_valid) begin
               // R11: one-hot outcome
               check($countones(rsp_action) == 1, "R11 onehot", rsp_action, 3'b010);
            end
            if (rsp_valid && rsp_ready) begin
               if (q.size() == 0) begin
                  check(1'b0, "R10 unexpected outcome", rsp_vector, 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(rsp_action == e.act && rsp_vector == e.vec, e.tag,
                        {21'd0, rsp_action, rsp_vector}, {21'd0, e.act, e.vec});
               end
            end
            held     = rsp_valid && !rsp_ready;
            held_act = rsp_action;
            held_vec = rsp_vector;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 reset",
            {rsp_valid, req_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 idle after reset", rsp_valid, 0);

      // R2: mask bit set, including where escalation would otherwise apply
      send(2'd1, 8'd13, 32'h0000_2000, 1'b0, "R2 exit over double fault");
      send(2'd2, 8'd14, 32'h0000_4000, 1'b0, "R2 exit page fault");
      send(2'd0, 8'd3,  32'h0000_0008, 1'b0, "R2 exit benign");
      send(2'd2, 8'd3,  32'h0000_0010, 1'b0, "R4 other mask bit");
      // R3: vectors above the mask width
      send(2'd2, 8'd40,  32'hFFFF_FFFF, 1'b0, "R3 high vector");
      send(2'd1, 8'd255, 32'hFFFF_FFFF, 1'b1, "R3 top vector");
      // R4 and R5
      send(2'd2, 8'd3,  32'h0, 1'b0, "R4 benign after page fault");
      send(2'd1, 8'd0,  32'h0, 1'b0, "R5 contrib after contrib");
      send(2'd1, 8'd12, 32'h0, 1'b0, "R5 contrib 12 after contrib");
      send(2'd0, 8'd11, 32'h0, 1'b0, "R5 contrib after benign");
      // R6 and R7
      send(2'd2, 8'd14, 32'h0, 1'b0, "R6 page fault after page fault");
      send(2'd1, 8'd14, 32'h0, 1'b0, "R6 page fault after contrib");
      send(2'd2, 8'd13, 32'h0, 1'b0, "R7 contrib after page fault");
      // R8: feature-dependent vector
      send(2'd2, 8'd20, 32'h0, 1'b0, "R8 vector 20 feature off");
      send(2'd2, 8'd20, 32'h0, 1'b1, "R8 vector 20 feature on");
      send(2'd1, 8'd20, 32'h0, 1'b1, "R8 vector 20 after contrib");
      // R9: reserved vectors and reserved first class
      send(2'd2, 8'd15, 32'h0, 1'b1, "R9 vector 15");
      send(2'd2, 8'd21, 32'h0, 1'b1, "R9 vector 21");
      send(2'd2, 8'd31, 32'h0, 1'b1, "R9 vector 31");
      send(2'd3, 8'd13, 32'h0, 1'b0, "R9 first class 3");

      // R10: full sweep under random back-pressure
      bp_on = 1'b1;
      for (int f = 0; f < 4; f++) begin
         for (int v = 0; v < 40; v++) begin
            for (int ve = 0; ve < 2; ve++) begin
               logic [31:0] m;
               m = {lfsr, lfsr ^ 16'h5A5A} & ((v % 3 == 0) ? 32'h0 : 32'hFFFF_FFFF);
               send(2'(f), 8'(v), m, ve[0], "R10 sweep");
            end
         end
      end
      bp_on = 1'b0;
      repeat (20) @(negedge clk);
      check(q.size() == 0, "R10 drained", q.size(), 0);
      finish_run();
   end

endmodule